// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block performs the memory traffic a processor core needs when it enters an exception handler and when it leaves one. On an entry request it takes the current program counter, status word and supervisor stack pointer. It pushes a three-word context frame onto the supervisor stack and fetches the handler address from the vector table. It then reports the new program counter, the adjusted status word and the lowered stack pointer. On a return request it pops the same frame back and reports the restored status word, the restored program counter and the raised stack pointer.

The core has a 24-bit byte address and a 16-bit data word. Every memory access is a single word transfer through a valid/ready port. The status word uses these bit positions: trace enable at bit 15, supervisor at bit 13, and the interrupt mask at bits 10..8. Which exception is taken, and when, is decided outside this block. The block only runs the sequence for the vector number and interrupt level it is given.

Top module: `exc_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_valid` are low.
- R2: An entry sequence issues three writes in this order: the low half of the PC (bits 15..0) to SSP−2, then the high half (bits 23..16 in the low byte, upper byte zero) to SSP−4, then the unadjusted SR to SSP−6.
- R3: On entry the reported SR has bit 13 set and bit 15 cleared. For a non-interrupt entry every other bit, including the mask bits 10..8, keeps its old value.
- R4: For an interrupt entry, mask bits 10..8 of the reported SR take `irq_level`. The other bits follow R3.
- R5: After the pushes, the entry reads the word at vector×4 and then the word at vector×4+2. The reported PC is {first word bits 7..0, second word}.
- R6: After an entry, the reported SSP is the old SSP minus 6.
- R7: A return reads SSP, SSP+2 and SSP+4, in that order. The reported SR is the first word, the PC is {second word bits 7..0, third word}, and the SSP is the old SSP plus 6.
- R8: `done` is high for exactly one cycle, starting the cycle after the final memory handshake. `new_pc`, `new_sr` and `new_ssp` hold the results from that cycle on, and `busy` is low while `done` is high.
- R9: Start strobes that arrive while `busy` is high are ignored. The running sequence and its results do not change.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` keep their values into the next cycle.
- R11: If both start strobes are high in the same idle cycle, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_entry | input | 1 | Begin an exception entry |
| start_return | input | 1 | Begin a return from exception |
| cur_pc | input | 24 | Resume address to save |
| cur_sr | input | 16 | Status word before the exception |
| cur_ssp | input | 24 | Supervisor stack pointer |
| vec_num | input | 8 | Vector number |
| is_irq | input | 1 | Entry is for an interrupt |
| irq_level | input | 3 | Accepted interrupt level |
| mem_valid | output | 1 | Memory request pending |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Word byte address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 24 | Handler address or restored PC |
| new_sr | output | 16 | Adjusted or restored status word |
| new_ssp | output | 24 | Updated stack pointer |

## Verification
The hardest situation to reach from the ports is a second start strobe that lands in the middle of a running sequence. The bench creates it by inserting memory wait states, so the sequence stays busy for many cycles. It then pulses both strobes, with different operands, partway through. The run must produce the same access log and the same results as an undisturbed run. The same wait states also hold requests pending across several cycles, and this is what exercises the hold rule of the memory port.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 16;
    localparam int VEC_W    = 8;
    localparam int LVL_W    = 3;
    localparam int WORD_B   = DATA_W / 8;
    localparam int FRAME_B  = 3 * WORD_B;
    localparam int SR_T_BIT = 15;
    localparam int SR_S_BIT = 13;
    localparam int SR_I_LSB = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_SR,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_POP_SR,
        ST_POP_PCH,
        ST_POP_PCL
    } seq_state_t;

    typedef struct packed {
        logic  write;
        addr_t addr;
        word_t wdata;
    } mem_req_t;

    function automatic logic is_write_state(seq_state_t s);
        return (s == ST_PUSH_PCL) || (s == ST_PUSH_PCH) || (s == ST_PUSH_SR);
    endfunction
endpackage

// File: rtl/exc_sr_adjust.sv
module exc_sr_adjust
    import exc_seq_pkg::*;
(
    input  word_t             sr_in,
    input  logic              is_irq,
    input  logic [LVL_W-1:0]  level,
    output word_t             sr_out
);
    always_comb begin
        sr_out = sr_in;
        sr_out[SR_S_BIT] = 1'b1;
        sr_out[SR_T_BIT] = 1'b0;
        if (is_irq)
            sr_out[SR_I_LSB +: LVL_W] = level;
    end
endmodule

// File: rtl/exc_step_addr.sv
module exc_step_addr
    import exc_seq_pkg::*;
(
    input  seq_state_t        state,
    input  addr_t             ssp,
    input  addr_t             pc,
    input  word_t             sr_old,
    input  logic [VEC_W-1:0]  vec,
    output mem_req_t          req
);
    localparam int PC_HI_W = ADDR_W - DATA_W;
    addr_t vec_base;

    assign vec_base = addr_t'({vec, 2'b00});

    always_comb begin
        req.write = is_write_state(state);
        req.addr  = '0;
        req.wdata = '0;
        unique case (state)
            ST_PUSH_PCL: begin
                req.addr  = ssp - addr_t'(WORD_B);
                req.wdata = pc[DATA_W-1:0];
            end
            ST_PUSH_PCH: begin
                req.addr  = ssp - addr_t'(2 * WORD_B);
                req.wdata = word_t'(pc[ADDR_W-1 -: PC_HI_W]);
            end
            ST_PUSH_SR: begin
                req.addr  = ssp - addr_t'(FRAME_B);
                req.wdata = sr_old;
            end
            ST_VEC_HI:  req.addr = vec_base;
            ST_VEC_LO:  req.addr = vec_base + addr_t'(WORD_B);
            ST_POP_SR:  req.addr = ssp;
            ST_POP_PCH: req.addr = ssp + addr_t'(WORD_B);
            ST_POP_PCL: req.addr = ssp + addr_t'(2 * WORD_B);
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_entry,
    input  logic        start_return,
    input  logic [23:0] cur_pc,
    input  logic [15:0] cur_sr,
    input  logic [23:0] cur_ssp,
    input  logic [7:0]  vec_num,
    input  logic        is_irq,
    input  logic [2:0]  irq_level,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [23:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [23:0] new_pc,
    output logic [15:0] new_sr,
    output logic [23:0] new_ssp
);
    localparam int PC_HI_W = ADDR_W - DATA_W;

    seq_state_t          state_q;
    addr_t               pc_q, ssp_q;
    word_t               sr_old_q, sr_res_q, sr_adj;
    logic [VEC_W-1:0]    vec_q;
    logic [PC_HI_W-1:0]  hi_q;
    mem_req_t            req;
    logic                hs;
    logic                done_q;
    addr_t               new_pc_q, new_ssp_q;
    word_t               new_sr_q;

    exc_sr_adjust u_adj (
        .sr_in (cur_sr),
        .is_irq(is_irq),
        .level (irq_level),
        .sr_out(sr_adj)
    );

    exc_step_addr u_addr (
        .state (state_q),
        .ssp   (ssp_q),
        .pc    (pc_q),
        .sr_old(sr_old_q),
        .vec   (vec_q),
        .req   (req)
    );

    assign mem_valid = (state_q != ST_IDLE);
    assign mem_write = req.write;
    assign mem_addr  = req.addr;
    assign mem_wdata = req.wdata;
    assign hs        = mem_valid && mem_ready;
    assign busy      = mem_valid;
    assign done      = done_q;
    assign new_pc    = new_pc_q;
    assign new_sr    = new_sr_q;
    assign new_ssp   = new_ssp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pc_q      <= '0;
            ssp_q     <= '0;
            sr_old_q  <= '0;
            sr_res_q  <= '0;
            vec_q     <= '0;
            hi_q      <= '0;
            done_q    <= 1'b0;
            new_pc_q  <= '0;
            new_sr_q  <= '0;
            new_ssp_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_entry || start_return) begin
                        pc_q     <= cur_pc;
                        ssp_q    <= cur_ssp;
                        sr_old_q <= cur_sr;
                        sr_res_q <= sr_adj;
                        vec_q    <= vec_num;
                        state_q  <= start_entry ? ST_PUSH_PCL : ST_POP_SR;
                    end
                end
                ST_PUSH_PCL: if (hs) state_q <= ST_PUSH_PCH;
                ST_PUSH_PCH: if (hs) state_q <= ST_PUSH_SR;
                ST_PUSH_SR:  if (hs) state_q <= ST_VEC_HI;
                ST_VEC_HI: if (hs) begin
                    hi_q    <= mem_rdata[PC_HI_W-1:0];
                    state_q <= ST_VEC_LO;
                end
                ST_VEC_LO: if (hs) begin
                    new_pc_q  <= {hi_q, mem_rdata};
                    new_sr_q  <= sr_res_q;
                    new_ssp_q <= ssp_q - addr_t'(FRAME_B);
                    done_q    <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                ST_POP_SR: if (hs) begin
                    sr_res_q <= mem_rdata;
                    state_q  <= ST_POP_PCH;
                end
                ST_POP_PCH: if (hs) begin
                    hi_q    <= mem_rdata[PC_HI_W-1:0];
                    state_q <= ST_POP_PCL;
                end
                ST_POP_PCL: if (hs) begin
                    new_pc_q  <= {hi_q, mem_rdata};
                    new_sr_q  <= sr_res_q;
                    new_ssp_q <= ssp_q + addr_t'(FRAME_B);
                    done_q    <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_wdata) && $stable(mem_write)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !hs) |=> (busy && $stable(mem_addr)));

    // R3
    sr_super_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) && $past(state_q == ST_VEC_LO) |-> (new_sr[SR_S_BIT] && !new_sr[SR_T_BIT]));
endmodule

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_entry = 1'b0, start_return = 1'b0;
    logic [23:0] cur_pc = '0, cur_ssp = '0;
    logic [15:0] cur_sr = '0;
    logic [7:0]  vec_num = '0;
    logic        is_irq = 1'b0;
    logic [2:0]  irq_level = '0;
    logic        mem_valid, mem_write, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        busy, done;
    logic [23:0] new_pc, new_ssp;
    logic [15:0] new_sr;

    int total = 0, bad = 0;
    int latency = 0, wcnt = 0;
    logic [15:0] mem [int];
    logic [23:0] log_addr [16];
    logic [15:0] log_data [16];
    logic        log_wr   [16];
    int          log_n = 0;

    always #4 clk = ~clk;

    exc_seq dut_i (.*);

    // memory model: responds at negedge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            wcnt      <= latency;
        end else if (mem_valid && !rst) begin
            if (wcnt == 0) begin
                mem_ready <= 1'b1;
                if (log_n < 16) begin
                    log_addr[log_n] = mem_addr;
                    log_wr[log_n]   = mem_write;
                    log_data[log_n] = mem_write ? mem_wdata : 16'h0;
                end
                log_n++;
                if (mem_write) mem[int'(mem_addr)] = mem_wdata;
                else mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
            end else wcnt <= wcnt - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_acc(input int i, input string tag, input bit wr, input logic [23:0] a, input logic [15:0] d);
        chk(log_wr[i] == wr && log_addr[i] == a && (!wr || log_data[i] == d), tag,
            {log_wr[i], log_addr[i][22:0], 8'h0} | 32'(log_data[i]), {wr, a[22:0], 8'h0} | 32'(d));
    endtask

    task automatic launch(input bit ent, input bit ret);
        log_n = 0;
        @(negedge clk);
        start_entry = ent; start_return = ret;
        @(negedge clk);
        start_entry = 1'b0; start_return = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
        chk(done, {tag, " done seen"}, 32'(done), 1);
    endtask

    task automatic set_in(input logic [23:0] pc, input logic [15:0] sr, input logic [23:0] sp,
                          input logic [7:0] v, input bit irq, input logic [2:0] lv);
        cur_pc = pc; cur_sr = sr; cur_ssp = sp; vec_num = v; is_irq = irq; irq_level = lv;
    endtask

    task automatic t_reset;
        chk(!busy && !done && !mem_valid, "R1 reset idle", {busy, done, mem_valid}, 0);
    endtask

    task automatic t_example;
        mem[32'h14] = 16'h0040; mem[32'h16] = 16'h0800;
        latency = 0;
        set_in(24'h001040, 16'h0016, 24'h004000, 8'd5, 1'b0, 3'd0);
        launch(1, 0);
        wait_done("example");
        chk(log_n == 5, "R2 access count", log_n, 5);
        chk_acc(0, "R2 push pc low", 1, 24'h003FFE, 16'h1040);
        chk_acc(1, "R2 push pc high", 1, 24'h003FFC, 16'h0000);
        chk_acc(2, "R2 push sr", 1, 24'h003FFA, 16'h0016);
        chk_acc(3, "R5 vec hi addr", 0, 24'h000014, 0);
        chk_acc(4, "R5 vec lo addr", 0, 24'h000016, 0);
        chk(new_pc == 24'h400800, "R5 new pc", new_pc, 24'h400800);
        chk(new_sr == 16'h2016, "R3 new sr", new_sr, 16'h2016);
        chk(new_ssp == 24'h003FFA, "R6 new ssp", new_ssp, 24'h003FFA);
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
        chk(new_pc == 24'h400800, "R8 result held", new_pc, 24'h400800);
    endtask

    task automatic t_return;
        latency = 1;
        set_in(24'h0, 16'h0, 24'h003FFA, 8'd0, 1'b0, 3'd0);
        launch(0, 1);
        wait_done("return");
        chk(log_n == 3, "R7 access count", log_n, 3);
        chk_acc(0, "R7 pop sr addr", 0, 24'h003FFA, 0);
        chk_acc(1, "R7 pop pch addr", 0, 24'h003FFC, 0);
        chk_acc(2, "R7 pop pcl addr", 0, 24'h003FFE, 0);
        chk(new_sr == 16'h0016, "R7 sr", new_sr, 16'h0016);
        chk(new_pc == 24'h001040, "R7 pc", new_pc, 24'h001040);
        chk(new_ssp == 24'h004000, "R7 ssp", new_ssp, 24'h004000);
    endtask

    task automatic t_irq;
        mem[32'h6C] = 16'hAB12; mem[32'h6E] = 16'h3456;
        latency = 2;
        set_in(24'hFEDCBA, 16'h8700, 24'h010000, 8'h1B, 1'b1, 3'd3);
        launch(1, 0);
        wait_done("irq");
        chk_acc(0, "R2 irq pc low", 1, 24'h00FFFE, 16'hDCBA);
        chk_acc(1, "R2 irq pc high", 1, 24'h00FFFC, 16'h00FE);
        chk_acc(2, "R2 irq old sr", 1, 24'h00FFFA, 16'h8700);
        chk(new_sr == 16'h2300, "R4 irq mask", new_sr, 16'h2300);
        chk(new_pc == 24'h123456, "R5 upper byte dropped", new_pc, 24'h123456);
        chk(new_ssp == 24'h00FFFA, "R6 irq ssp", new_ssp, 24'h00FFFA);
    endtask

    task automatic t_nonirq_mask;
        mem[32'h3FC] = 16'h0001; mem[32'h3FE] = 16'h2222;
        latency = 0;
        set_in(24'h000100, 16'h0515, 24'h000800, 8'hFF, 1'b0, 3'd7);
        launch(1, 0);
        wait_done("mask");
        chk(new_sr == 16'h2515, "R3 mask kept", new_sr, 16'h2515);
        chk_acc(3, "R5 top vector", 0, 24'h0003FC, 0);
        chk(new_pc == 24'h012222, "R5 top vector pc", new_pc, 24'h012222);
    endtask

    task automatic t_busy_ignore;
        latency = 3;
        set_in(24'h001040, 16'h0016, 24'h004000, 8'd5, 1'b0, 3'd0);
        launch(1, 0);
        repeat (6) @(negedge clk);
        set_in(24'h777777, 16'hFFFF, 24'h000200, 8'd9, 1'b1, 3'd6);
        start_entry = 1'b1; start_return = 1'b1;
        @(negedge clk);
        start_entry = 1'b0; start_return = 1'b0;
        wait_done("busy");
        chk(log_n == 5, "R9 no extra access", log_n, 5);
        chk_acc(2, "R9 frame unchanged", 1, 24'h003FFA, 16'h0016);
        chk(new_pc == 24'h400800 && new_ssp == 24'h003FFA, "R9 results unchanged", new_pc, 24'h400800);
        chk(new_sr == 16'h2016, "R9 sr unchanged", new_sr, 16'h2016);
        repeat (3) @(negedge clk);
        chk(!busy, "R9 no restart", busy, 0);
    endtask

    task automatic t_both;
        latency = 0;
        set_in(24'h000010, 16'h0000, 24'h002000, 8'd5, 1'b0, 3'd0);
        launch(1, 1);
        wait_done("both");
        chk(log_wr[0] == 1'b1 && log_n == 5, "R11 entry wins", log_n, 5);
        chk(new_ssp == 24'h001FFA, "R11 ssp", new_ssp, 24'h001FFA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_example();
        t_return();
        t_irq();
        t_nonirq_mask();
        t_busy_ignore();
        t_both();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule